// File: doc/BRIEF.md
# Ready/Valid Link Protocol Monitor

This block watches a single ready/valid/data link inside one clock domain and never drives it. On every cycle it sorts the link into one of four conditions: both handshake lines low, the receiver ready and waiting for valid, the transmitter offering data and waiting for ready, or a completed transfer. The current condition is reported as a 2-bit code.

From that classification the monitor enforces the handshake rules. The transmitter must keep valid high and the data unchanged while it is stalled. A build-time option adds a stricter rule for the receiver: it must keep ready high until valid arrives. Each broken rule sets its own sticky error bit, and a combined flag collects all of them.

Two saturating counters give a coverage view of the link. One counts transfer cycles and the other counts backpressure cycles. A testbench or a status path reads them after the run.

The rule checker is a small state machine. Its state register holds the previous cycle's classification:
- `ST_UNARMED`: no sample has been taken since reset.
- `ST_IDLE`, `ST_RX_WAIT`, `ST_TX_WAIT`, `ST_XFER`: the four link conditions.

Each clock edge moves the machine to the condition sampled on that edge. Reset forces `ST_UNARMED`. From `ST_UNARMED` no rule is evaluated, so the first cycle after reset is never compared against values held from before the reset.

Top module: `rv_link_monitor`

## Requirements
- R1: `state_code` follows the present inputs with no clock delay: 2'b00 when valid and ready are both low, 2'b01 when only ready is high, 2'b10 when only valid is high, and 2'b11 when both are high.
- R2: `xfer_count` rises by one after each clock edge, taken out of reset, at which ready and valid are both high.
- R3: `stall_count` rises by one after each clock edge, taken out of reset, at which valid is high and ready is low.
- R4: Both counters saturate at all ones (2^CNT_W − 1) and never wrap.
- R5: Suppose an edge samples valid high and ready low, and the next edge samples valid low. Then `err_tx_valid_drop` is 1 after that next edge.
- R6: Suppose an edge samples valid high and ready low, and the next edge samples data different from the data of that first edge. Then `err_tx_data_change` is 1 after that next edge.
- R7: With STRICT_READY = 1, suppose an edge samples ready high and valid low, and the next edge samples ready low. Then `err_rx_ready_drop` is 1 after that next edge.
- R8: With STRICT_READY = 0, `err_rx_ready_drop` stays 0 under any stimulus, and a receiver that drops ready does not set `err_any`.
- R9: Every error bit stays set until reset. `err_any` is the OR of the three error bits.
- R10: A clock edge with `rst` high has these effects:
  - it clears both counters and all error bits;
  - it counts nothing;
  - it leaves nothing for the next cycle's rules to compare against, so the first edge after reset can raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| link_ready | input | 1 | Receiver ready, as sampled on the link |
| link_valid | input | 1 | Transmitter valid, as sampled on the link |
| link_data | input | DATA_W | Link data bus |
| state_code | output | 2 | Present link condition (see R1) |
| err_tx_valid_drop | output | 1 | Sticky: valid withdrawn while stalled |
| err_tx_data_change | output | 1 | Sticky: data altered while stalled |
| err_rx_ready_drop | output | 1 | Sticky: ready withdrawn before valid (strict build only) |
| err_any | output | 1 | OR of all error bits |
| xfer_count | output | CNT_W | Saturating count of transfer cycles |
| stall_count | output | CNT_W | Saturating count of backpressure cycles |

## Verification
The bound properties check the following on every cycle:
- each counter steps by exactly one on a transfer or stall edge, and holds once saturated;
- a stalled transmitter that drops valid or alters data raises the matching error on the following edge;
- in the strict build, an early ready drop raises its error in the same way;
- errors never clear without reset;
- a reset edge leaves counters and errors clear.

Only the directed scenarios can show the rest:
- the exact combinational state codes;
- that lawful traffic raises no error at all;
- that the relaxed build ignores a ready drop;
- that a stall straddling a reset is forgiven;
- that the two counters saturate separately in a narrow build.

// File: rtl/rvm_pkg.sv
package rvm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RX_WAIT = 3'd1,
        ST_TX_WAIT = 3'd2,
        ST_XFER    = 3'd3,
        ST_UNARMED = 3'd4
    } link_st_e;

    typedef struct packed {
        logic valid_drop;
        logic data_change;
        logic ready_drop;
    } viol_t;

    localparam int VIOL_W = 3;

endpackage

// File: rtl/rvm_classifier.sv
module rvm_classifier
    import rvm_pkg::*;
(
    input  logic       rdy,
    input  logic       vld,
    output link_st_e   cur_st,
    output logic [1:0] code,
    output logic       is_xfer,
    output logic       is_stall
);

    always_comb begin
        unique case ({vld, rdy})
            2'b00:   cur_st = ST_IDLE;
            2'b01:   cur_st = ST_RX_WAIT;
            2'b10:   cur_st = ST_TX_WAIT;
            default: cur_st = ST_XFER;
        endcase
    end

    always_comb begin
        is_xfer  = 1'b0;
        is_stall = 1'b0;
        code     = 2'b00;
        unique case (cur_st)
            ST_IDLE:    code = 2'b00;
            ST_RX_WAIT: code = 2'b01;
            ST_TX_WAIT: begin
                code     = 2'b10;
                is_stall = 1'b1;
            end
            ST_XFER: begin
                code    = 2'b11;
                is_xfer = 1'b1;
            end
            default: code = 2'b00;
        endcase
    end

endmodule

// File: rtl/rvm_rule_checker.sv
module rvm_rule_checker
    import rvm_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter bit STRICT_READY = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  link_st_e          cur_st,
    input  logic [DATA_W-1:0] data,
    output viol_t             flags
);

    link_st_e          prev_st;
    logic [DATA_W-1:0] prev_data;
    viol_t             hits;
    logic              tx_hold_broken_v;
    logic              tx_hold_broken_d;
    logic              rx_hold_broken;

    // State register: remembers the previous sampled condition.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_st   <= ST_UNARMED;
            prev_data <= '0;
        end else begin
            prev_st   <= cur_st;
            prev_data <= data;
        end
    end

    // Output process: decide which rule the present cycle breaks.
    always_comb begin
        tx_hold_broken_v = 1'b0;
        tx_hold_broken_d = 1'b0;
        unique case (prev_st)
            ST_UNARMED: begin
                tx_hold_broken_v = 1'b0;
                tx_hold_broken_d = 1'b0;
            end
            ST_TX_WAIT: begin
                tx_hold_broken_v = (cur_st != ST_TX_WAIT) && (cur_st != ST_XFER);
                tx_hold_broken_d = (data != prev_data);
            end
            ST_IDLE, ST_RX_WAIT, ST_XFER: begin
                tx_hold_broken_v = 1'b0;
                tx_hold_broken_d = 1'b0;
            end
            default: begin
                tx_hold_broken_v = 1'b0;
                tx_hold_broken_d = 1'b0;
            end
        endcase
    end

    generate
        if (STRICT_READY) begin : g_strict
            always_comb begin
                unique case (prev_st)
                    ST_RX_WAIT: rx_hold_broken = (cur_st == ST_IDLE) || (cur_st == ST_TX_WAIT);
                    default:    rx_hold_broken = 1'b0;
                endcase
            end
        end else begin : g_lax
            assign rx_hold_broken = 1'b0;
        end
    endgenerate

    always_comb begin
        hits.valid_drop  = tx_hold_broken_v;
        hits.data_change = tx_hold_broken_d;
        hits.ready_drop  = rx_hold_broken;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= flags | hits;
        end
    end

endmodule

// File: rtl/rvm_sat_counter.sv
module rvm_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc && (count != TOP)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/rv_link_monitor.sv
module rv_link_monitor
    import rvm_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter bit STRICT_READY = 1'b1,
    parameter int CNT_W        = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              link_ready,
    input  logic              link_valid,
    input  logic [DATA_W-1:0] link_data,
    output logic [1:0]        state_code,
    output logic              err_tx_valid_drop,
    output logic              err_tx_data_change,
    output logic              err_rx_ready_drop,
    output logic              err_any,
    output logic [CNT_W-1:0]  xfer_count,
    output logic [CNT_W-1:0]  stall_count
);

    localparam int N_CNT = 2;

    link_st_e         cur_st;
    logic             is_xfer;
    logic             is_stall;
    viol_t            flags;
    logic [N_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0] cnt_val [N_CNT];

    rvm_classifier u_classify (
        .rdy      (link_ready),
        .vld      (link_valid),
        .cur_st   (cur_st),
        .code     (state_code),
        .is_xfer  (is_xfer),
        .is_stall (is_stall)
    );

    rvm_rule_checker #(
        .DATA_W       (DATA_W),
        .STRICT_READY (STRICT_READY)
    ) u_rules (
        .clk    (clk),
        .rst    (rst),
        .cur_st (cur_st),
        .data   (link_data),
        .flags  (flags)
    );

    assign cnt_inc = {is_stall, is_xfer};

    generate
        for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
            rvm_sat_counter #(.W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst   (rst),
                .inc   (cnt_inc[i]),
                .count (cnt_val[i])
            );
        end
    endgenerate

    assign xfer_count         = cnt_val[0];
    assign stall_count        = cnt_val[1];
    assign err_tx_valid_drop  = flags.valid_drop;
    assign err_tx_data_change = flags.data_change;
    assign err_rx_ready_drop  = flags.ready_drop;
    assign err_any            = |flags;

endmodule

// File: rtl/rvm_sva.sv
module rvm_sva #(
    parameter int DATA_W       = 8,
    parameter bit STRICT_READY = 1'b1,
    parameter int CNT_W        = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              link_ready,
    input logic              link_valid,
    input logic [DATA_W-1:0] link_data,
    input logic              err_tx_valid_drop,
    input logic              err_tx_data_change,
    input logic              err_rx_ready_drop,
    input logic              err_any,
    input logic [CNT_W-1:0]  xfer_count,
    input logic [CNT_W-1:0]  stall_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    AST_XFER_STEP: assert property (@(posedge clk) disable iff (rst)
        (link_ready && link_valid && xfer_count != CNT_MAX) |=> (xfer_count == $past(xfer_count) + 1'b1)); // R2

    AST_STALL_STEP: assert property (@(posedge clk) disable iff (rst)
        (link_valid && !link_ready && stall_count != CNT_MAX) |=> (stall_count == $past(stall_count) + 1'b1)); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (xfer_count == CNT_MAX) |=> (xfer_count == CNT_MAX)); // R4

    AST_STALL_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (stall_count == CNT_MAX) |=> (stall_count == CNT_MAX)); // R4

    AST_VALID_DROP_FLAG: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(link_valid && !link_ready) && !link_valid) |=> err_tx_valid_drop); // R5

    AST_DATA_HOLD_FLAG: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(link_valid && !link_ready) && (link_data != $past(link_data))) |=> err_tx_data_change); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_any |=> err_any); // R9

    AST_CLEAN_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!err_any && xfer_count == '0 && stall_count == '0)); // R10

    generate
        if (STRICT_READY) begin : g_strict_chk
            AST_READY_HOLD_FLAG: assert property (@(posedge clk) disable iff (rst)
                ($past(!rst) && $past(link_ready && !link_valid) && !link_ready) |=> err_rx_ready_drop); // R7
        end
    endgenerate

endmodule

bind rv_link_monitor rvm_sva #(
    .DATA_W       (DATA_W),
    .STRICT_READY (STRICT_READY),
    .CNT_W        (CNT_W)
) u_sva (
    .clk                (clk),
    .rst                (rst),
    .link_ready         (link_ready),
    .link_valid         (link_valid),
    .link_data          (link_data),
    .err_tx_valid_drop  (err_tx_valid_drop),
    .err_tx_data_change (err_tx_data_change),
    .err_rx_ready_drop  (err_rx_ready_drop),
    .err_any            (err_any),
    .xfer_count         (xfer_count),
    .stall_count        (stall_count)
);

// File: tb/test_rv_link_monitor.sv
module test_rv_link_monitor;

    localparam int DW = 8;
    localparam int CW = 32;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rdy = 1'b0;
    logic          vld = 1'b0;
    logic [DW-1:0] dat = '0;

    logic [1:0]    code;
    logic          e_vd, e_dc, e_rd, e_any;
    logic [CW-1:0] xc, sc;

    logic [1:0]    code_l;
    logic          l_vd, l_dc, l_rd, l_any;
    logic [LW-1:0] xc_l, sc_l;

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    rv_link_monitor #(.DATA_W(DW), .STRICT_READY(1'b1), .CNT_W(CW)) i_rv_link_monitor (
        .clk(clk), .rst(rst), .link_ready(rdy), .link_valid(vld), .link_data(dat),
        .state_code(code), .err_tx_valid_drop(e_vd), .err_tx_data_change(e_dc),
        .err_rx_ready_drop(e_rd), .err_any(e_any), .xfer_count(xc), .stall_count(sc)
    );

    rv_link_monitor #(.DATA_W(DW), .STRICT_READY(1'b0), .CNT_W(LW)) i_rv_link_monitor_lax (
        .clk(clk), .rst(rst), .link_ready(rdy), .link_valid(vld), .link_data(dat),
        .state_code(code_l), .err_tx_valid_drop(l_vd), .err_tx_data_change(l_dc),
        .err_rx_ready_drop(l_rd), .err_any(l_any), .xfer_count(xc_l), .stall_count(sc_l)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Apply one cycle of inputs at the falling edge.
    task automatic step(input logic r, input logic v, input logic [DW-1:0] d);
        @(negedge clk);
        rdy = r;
        vld = v;
        dat = d;
    endtask

    // Let the last applied inputs be taken by a rising edge.
    task automatic settle();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        rdy = 1'b0;
        vld = 1'b0;
        dat = '0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        #1;
        chk("R10 xfer clear", xc, 0);
        chk("R10 stall clear", sc, 0);
        chk("R10 err clear", {e_vd, e_dc, e_rd, e_any}, 0);
        chk("R1 idle code", code, 2'b00);
    endtask

    task automatic t_state_codes();
        do_reset();
        step(0, 0, 8'h11); #1; chk("R1 code 00", code, 2'b00);
        step(0, 1, 8'h22); #1; chk("R1 code 10", code, 2'b10);
        step(1, 1, 8'h22); #1; chk("R1 code 11", code, 2'b11);
        step(1, 0, 8'h33); #1; chk("R1 code 01", code, 2'b01);
        step(1, 1, 8'h44); #1; chk("R1 code 11 again", code, 2'b11);
        step(0, 0, 8'h00);
        settle();
        chk("R2 two transfers", xc, 2);
        chk("R3 one stall", sc, 1);
        chk("R9 lawful traffic no error", e_any, 0);
    endtask

    task automatic t_backpressure();
        do_reset();
        for (int i = 0; i < 3; i++) step(0, 1, 8'hA5);
        step(1, 1, 8'hA5);
        step(0, 0, 8'h00);
        settle();
        chk("R3 three stalls", sc, 3);
        chk("R2 one transfer", xc, 1);
        chk("R5 held valid no flag", e_vd, 0);
        chk("R6 held data no flag", e_dc, 0);
    endtask

    task automatic t_valid_drop();
        do_reset();
        step(0, 1, 8'h5A);
        step(0, 0, 8'h5A);
        settle();
        chk("R5 valid drop flag", e_vd, 1);
        chk("R5 lax build flags too", l_vd, 1);
        chk("R6 same data no flag", e_dc, 0);
        chk("R9 any set", e_any, 1);
        for (int i = 0; i < 4; i++) step(1, 1, 8'h01);
        step(0, 0, 8'h00);
        settle();
        chk("R9 sticky valid drop", e_vd, 1);
        do_reset();
        #1;
        chk("R10 reset clears sticky", {e_vd, e_any}, 0);
    endtask

    task automatic t_data_change();
        do_reset();
        step(0, 1, 8'h05);
        step(0, 1, 8'h06);
        settle();
        chk("R6 data change flag", e_dc, 1);
        chk("R5 valid held no flag", e_vd, 0);
        chk("R9 any set", e_any, 1);
    endtask

    task automatic t_ready_drop();
        do_reset();
        step(1, 0, 8'h00);
        step(0, 0, 8'h00);
        settle();
        chk("R7 strict ready drop flag", e_rd, 1);
        chk("R9 strict any set", e_any, 1);
        chk("R8 lax ready drop clear", l_rd, 0);
        chk("R8 lax any clear", l_any, 0);
    endtask

    task automatic t_reset_boundary();
        do_reset();
        step(0, 1, 8'h77);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        vld = 1'b0;
        dat = 8'h00;
        settle();
        chk("R10 no error across reset", e_any, 0);
        chk("R10 reset edge counts nothing", sc, 0);
    endtask

    task automatic t_saturate();
        do_reset();
        for (int i = 0; i < 20; i++) step(1, 1, 8'hC3);
        for (int i = 0; i < 18; i++) step(0, 1, 8'hC3);
        step(1, 1, 8'hC3);
        step(0, 0, 8'h00);
        settle();
        chk("R4 narrow xfer saturates", xc_l, 15);
        chk("R4 narrow stall saturates", sc_l, 15);
        chk("R2 wide xfer keeps counting", xc, 21);
        chk("R3 wide stall keeps counting", sc, 18);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_state_codes();
        t_backpressure();
        t_valid_drop();
        t_data_change();
        t_ready_drop();
        t_reset_boundary();
        t_saturate();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule